// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block decides which of several interrupt sources the CPU takes next and keeps the CPU's current priority level as routines nest. Each source has an enable bit and a 4-bit level. A pulse on a source's request line is latched as pending. Every cycle, the block picks the best pending request and compares it with the CPU level and the global enable. It then acknowledges that request in one of two ways: through a normal service entry or through a single-cycle transfer channel that steals a cycle.

The status word holds the level and the global enable. It sits on an internal stack. Normal service entries and both kinds of trap push it, and a return pulse pops it. Software can overwrite the status word through a write strobe. Hardware traps are never masked and raise the level to its maximum. Software traps keep the level as it is. A pending, enabled request at level 0 cannot be serviced, but it raises a wake signal.

Top module: `prio_nest_ctrl`

## Requirements
- R1: A request at level 0 is never acknowledged. The reset state is: level 0, global enable clear, stack empty, no pending request, all outputs low.
- R2: A pending, enabled request is acknowledged only when the global enable is set and its level is strictly greater than the CPU level. The acknowledge is a one-cycle `ack_o` pulse in the cycle after the decision. `ack_idx_o` carries the source index during that pulse and is 0 otherwise.
- R3: A normal acknowledge first pushes the status word, then loads the CPU level with the winning level.
- R4: Among eligible requests, the highest level wins. When levels are equal, the lowest source index wins.
- R5: A winner whose level has bit 3 set and whose transfer channel bit in `pec_en_i` is set is served as a transfer. Both `ack_o` and `pec_o` pulse, and neither the level nor the stack changes.
- R6: `hw_trap_i` pushes the status word and sets the level to 15, whatever the global enable. Until the level is lowered again, nothing is acknowledged.
- R7: `sw_trap_i` pushes the status word and leaves the level unchanged.
- R8: `wake_o` is high while any pending request whose source is enabled has level 0, whatever the global enable.
- R9: While the global enable is clear, neither `ack_o` nor `pec_o` pulses. A `psw_wr_i` pulse loads the level and the global enable.
- R10: `reti_i` pops the stack and restores both the level and the global enable. A push onto a full stack or a pop from an empty stack sets the sticky `stk_err_o` and leaves the stack unchanged. On such a push the level update still applies.
- R11: Only a request pulse arriving while its source is enabled becomes pending. The pending bit is cleared at the same edge that produces the acknowledge.
- R12: When events coincide in one cycle, the priority is: hardware trap, then software trap, then return, then status write. Any of these blocks acceptance of a request in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_SRC | Request pulse per source |
| src_en_i | input | N_SRC | Enable bit per source |
| src_lvl_i | input | N_SRC*LVLW | Level per source, source i at bits i*LVLW upward |
| pec_en_i | input | N_SRC | Transfer channel enabled per source |
| psw_wr_i | input | 1 | Status word write strobe |
| psw_lvl_i | input | LVLW | Level to write |
| psw_gie_i | input | 1 | Global enable to write |
| hw_trap_i | input | 1 | Hardware trap strobe |
| sw_trap_i | input | 1 | Software trap strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ack_o | output | 1 | Acknowledge pulse |
| ack_idx_o | output | clog2(N_SRC) | Index of the acknowledged source |
| pec_o | output | 1 | Transfer strobe |
| wake_o | output | 1 | Wake request from level-0 sources |
| lvl_o | output | LVLW | Current CPU level |
| gie_o | output | 1 | Current global enable |
| stk_err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench builds the block with six sources and a stack only four entries deep. At that depth, a short burst of hardware traps reaches overflow and a burst of returns reaches underflow within a few cycles. The 4-bit level is kept, so the split between the upper and lower half of the levels, and the maximum trap level, behave exactly as in the default build. Six sources are few enough that random request pulses often meet equal levels, which exercises the lowest-index tie-break alongside directed scenarios for nesting and the two trap kinds.

// File: rtl/prio_nest_ctrl.sv
module prio_nest_ctrl #(
  parameter int N_SRC     = 8,
  parameter int LVLW      = 4,
  parameter int STK_DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SRC-1:0]          req_i,
  input  logic [N_SRC-1:0]          src_en_i,
  input  logic [N_SRC*LVLW-1:0]     src_lvl_i,
  input  logic [N_SRC-1:0]          pec_en_i,
  input  logic                      psw_wr_i,
  input  logic [LVLW-1:0]           psw_lvl_i,
  input  logic                      psw_gie_i,
  input  logic                      hw_trap_i,
  input  logic                      sw_trap_i,
  input  logic                      reti_i,
  output logic                      ack_o,
  output logic [$clog2(N_SRC)-1:0]  ack_idx_o,
  output logic                      pec_o,
  output logic                      wake_o,
  output logic [LVLW-1:0]           lvl_o,
  output logic                      gie_o,
  output logic                      stk_err_o
);
  localparam int IW  = $clog2(N_SRC);
  localparam int SPW = $clog2(STK_DEPTH + 1);
  localparam int SAW = $clog2(STK_DEPTH);
  localparam logic [LVLW-1:0] LMAX = '1;

  logic [LVLW-1:0]  lvl_q;
  logic             gie_q;
  logic [N_SRC-1:0] pend_q;
  logic [SPW-1:0]   sp_q;
  logic [LVLW:0]    stk_q [STK_DEPTH];
  logic             err_q;

  logic             found;
  logic [IW-1:0]    win_idx;
  logic [LVLW-1:0]  win_lvl;
  logic [N_SRC-1:0] zero_lvl;

  for (genvar g = 0; g < N_SRC; g++) begin : g_zero
    assign zero_lvl[g] = (src_lvl_i[g*LVLW +: LVLW] == '0);
  end

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_q[i] && src_en_i[i] && !zero_lvl[i] &&
          src_lvl_i[i*LVLW +: LVLW] >= win_lvl) begin
        found   = 1'b1;
        win_idx = IW'(i);
        win_lvl = src_lvl_i[i*LVLW +: LVLW];
      end
    end
  end

  logic busy, take, to_pec, push, pop, full, empty;
  assign busy   = hw_trap_i | sw_trap_i | reti_i | psw_wr_i;
  assign take   = found && gie_q && (win_lvl > lvl_q) && !busy;
  assign to_pec = take && win_lvl[LVLW-1] && pec_en_i[win_idx];
  assign push   = hw_trap_i | sw_trap_i | (take & ~to_pec);
  assign pop    = reti_i & ~hw_trap_i & ~sw_trap_i;
  assign full   = (sp_q == SPW'(STK_DEPTH));
  assign empty  = (sp_q == '0);

  always_ff @(posedge clk) begin
    if (push && !full) stk_q[SAW'(sp_q)] <= {gie_q, lvl_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q     <= '0;
      gie_q     <= 1'b0;
      pend_q    <= '0;
      sp_q      <= '0;
      err_q     <= 1'b0;
      ack_o     <= 1'b0;
      ack_idx_o <= '0;
      pec_o     <= 1'b0;
    end else begin
      ack_o     <= take;
      ack_idx_o <= take ? win_idx : '0;
      pec_o     <= to_pec;
      pend_q    <= (pend_q & ~(take ? (N_SRC'(1) << win_idx) : '0)) | (req_i & src_en_i);
      if (push) begin
        if (full) err_q <= 1'b1;
        else      sp_q  <= sp_q + 1'b1;
      end else if (pop) begin
        if (empty) err_q <= 1'b1;
        else begin
          {gie_q, lvl_q} <= stk_q[SAW'(sp_q - 1'b1)];
          sp_q           <= sp_q - 1'b1;
        end
      end
      if (hw_trap_i)                      lvl_q <= LMAX;
      else if (!sw_trap_i && !reti_i && psw_wr_i) begin
        lvl_q <= psw_lvl_i;
        gie_q <= psw_gie_i;
      end else if (take && !to_pec && !sw_trap_i) lvl_q <= win_lvl;
    end
  end

  assign wake_o    = |(pend_q & src_en_i & zero_lvl);
  assign lvl_o     = lvl_q;
  assign gie_o     = gie_q;
  assign stk_err_o = err_q;

  a_r3_ack_raises_level: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o && !pec_o |-> lvl_q > $past(lvl_q));
  a_r5_pec_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    pec_o |-> lvl_q == $past(lvl_q) && sp_q == $past(sp_q));
  a_r6_trap_max_level: assert property (@(posedge clk) disable iff (!rst_n)
    hw_trap_i |=> lvl_q == LMAX);
  a_r7_swtrap_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trap_i && !hw_trap_i |=> $stable(lvl_q));
  a_r9_gie_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |=> !ack_o && !pec_o);
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  a_r2_idx_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o |-> ack_idx_o == '0 && !pec_o);
endmodule

// File: tb/test_prio_nest_ctrl.sv
`timescale 1ns/1ps
module test_prio_nest_ctrl;
  localparam int N = 6, LW = 4, D = 4, IW = $clog2(N);
  localparam int LMAX = (1 << LW) - 1;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = '0, en = '0, pen = '0;
  logic [N*LW-1:0] lv = '0;
  logic psw_wr = 0, psw_gie = 0, hw = 0, sw = 0, reti = 0;
  logic [LW-1:0] psw_lvl = '0;
  logic ack, pec, wake, gie, err;
  logic [IW-1:0] idx;
  logic [LW-1:0] lvl;

  always #2 clk = ~clk;

  prio_nest_ctrl #(.N_SRC(N), .LVLW(LW), .STK_DEPTH(D)) i_prio_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .src_en_i(en), .src_lvl_i(lv),
    .pec_en_i(pen), .psw_wr_i(psw_wr), .psw_lvl_i(psw_lvl), .psw_gie_i(psw_gie),
    .hw_trap_i(hw), .sw_trap_i(sw), .reti_i(reti), .ack_o(ack), .ack_idx_o(idx),
    .pec_o(pec), .wake_o(wake), .lvl_o(lvl), .gie_o(gie), .stk_err_o(err));

  int checks = 0, fails = 0;
  int m_lvl, m_gie, m_err, m_ack, m_pec, m_idx, m_ev;
  bit m_pend[N];
  int stk[$];

  function automatic int lvl_of(int i);
    return int'(lv[i*LW +: LW]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lvl = 0; m_gie = 0; m_err = 0; m_ack = 0; m_pec = 0; m_idx = 0; m_ev = 0;
      foreach (m_pend[i]) m_pend[i] = 0;
      stk.delete();
    end else begin
      int best, bi;
      bit take, tp, evb;
      best = 0; bi = -1;
      for (int i = 0; i < N; i++)
        if (m_pend[i] && en[i] && lvl_of(i) > best) begin best = lvl_of(i); bi = i; end
      evb  = hw || sw || reti || psw_wr;
      take = (bi >= 0) && m_gie == 1 && best > m_lvl && !evb;
      tp   = take && best >= 8 && pen[bi];
      m_ack = take; m_pec = tp; m_idx = take ? bi : 0;
      if (take) m_pend[bi] = 0;
      for (int i = 0; i < N; i++) if (req[i] && en[i]) m_pend[i] = 1;
      m_ev = 0;
      if (hw || sw || (take && !tp)) begin
        if (stk.size() == D) m_err = 1;
        else stk.push_back(m_gie * 64 + m_lvl);
        if (hw) begin m_lvl = LMAX; m_ev = 1; end
        else if (sw) m_ev = 2;
        else begin m_lvl = best; m_ev = 4; end
      end else if (reti) begin
        m_ev = 3;
        if (stk.size() == 0) m_err = 1;
        else begin int w; w = stk.pop_back(); m_gie = w / 64; m_lvl = w % 64; end
      end else if (psw_wr) begin
        m_lvl = psw_lvl; m_gie = psw_gie; m_ev = 5;
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    begin
      int mw;
      string lt;
      mw = 0;
      for (int i = 0; i < N; i++) if (m_pend[i] && en[i] && lvl_of(i) == 0) mw = 1;
      case (m_ev)
        1: lt = "R6 level after hardware trap";
        2: lt = "R7 level after software trap";
        3: lt = "R10 level after return";
        5: lt = "R9 level after status write";
        default: lt = "R3 R12 level";
      endcase
      chk(int'(ack), m_ack, "R2 R1 R11 ack_o");
      chk(int'(idx), m_idx, "R4 ack_idx_o");
      chk(int'(pec), m_pec, "R5 pec_o");
      chk(int'(wake), mw, "R8 wake_o");
      chk(int'(lvl), m_lvl, lt);
      chk(int'(gie), m_gie, "R9 R10 gie_o");
      chk(int'(err), m_err, "R10 stk_err_o");
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req(input logic [N-1:0] r);
    req = r; @(negedge clk); req = '0;
  endtask

  task automatic pulse_ev(input int k);
    case (k)
      0: hw = 1;
      1: sw = 1;
      2: reti = 1;
      default: psw_wr = 1;
    endcase
    @(negedge clk);
    hw = 0; sw = 0; reti = 0; psw_wr = 0;
  endtask

  task automatic set_lvl(input int i, input int v);
    lv[i*LW +: LW] = LW'(v);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog R12: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    idle(1);
    // R1 reset state checked by the per-cycle comparison
    en = '1; pen = 6'b100100;
    set_lvl(0, 0); set_lvl(1, 3); set_lvl(2, 9); set_lvl(3, 5); set_lvl(4, 5); set_lvl(5, 12);
    pulse_req(6'b000001); idle(3);                 // R8 wake with enable clear, R1
    psw_gie = 1; psw_lvl = 0; pulse_ev(3); idle(2); // R9
    pulse_req(6'b000010); idle(3);                 // R2 R3
    pulse_ev(1); idle(2);                          // R7
    pulse_req(6'b011000); idle(4);                 // R4 tie at level 5
    pulse_req(6'b000100); idle(3);                 // R5 transfer
    pulse_ev(0); pulse_req(6'b100000); idle(3);    // R6 blocked at max
    pulse_ev(2); idle(3);                          // R10 restore, then transfer
    en[1] = 0; pulse_req(6'b000010); en[1] = 1; idle(3); // R11
    hw = 1; req = 6'b000010; @(negedge clk); hw = 0; req = '0; idle(2); // R12
    psw_gie = 0; psw_lvl = 0; pulse_ev(3); pulse_req(6'b001000); idle(3); // R9
    repeat (8) pulse_ev(2);                        // R10 underflow
    repeat (6) pulse_ev(0);                        // R10 overflow
    rst_n = 0; idle(2); rst_n = 1; idle(1);
    psw_gie = 1; psw_lvl = 0; pulse_ev(3);
    for (int c = 0; c < 3000; c++) begin
      if (c % 100 == 0) for (int i = 0; i < N; i++) set_lvl(i, int'($urandom_range(0, LMAX)));
      if (c % 200 == 0) begin en = N'($urandom) | N'(6'b110011); pen = N'($urandom); end
      req = N'($urandom) & N'($urandom);
      hw = ($urandom_range(0, 59) == 0);
      sw = ($urandom_range(0, 39) == 0);
      reti = ($urandom_range(0, 5) == 0);
      psw_wr = ($urandom_range(0, 49) == 0);
      psw_gie = ($urandom_range(0, 7) != 0);
      psw_lvl = LW'($urandom_range(0, 6));
      @(negedge clk);
    end
    req = '0; hw = 0; sw = 0; reti = 0; psw_wr = 0;
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule